// File: doc/BRIEF.md
# Prioritized Interrupt Level Acceptor

This block sits beside a processor core and decides when one of seven prioritized interrupt request lines may break into the program. Each cycle it finds the highest-numbered pending level. It compares that level with the 3-bit mask held in its own status bits. It accepts the request only on a cycle where the core reports an instruction boundary. Level 7 is non-maskable. It is taken on a rising edge of its line, so a level-7 line that stays high is not taken again and again.

After it accepts a request, the block raises an acknowledge that carries the accepted level. It waits for the interrupting device to return an 8-bit vector number. If no device answers within a fixed window, it uses the spurious-interrupt vector instead. It then presents the vector number and the byte address of its entry in the vector table, which is four times the number. It holds a stacking request until the core reports that the program counter and status have been pushed.

On acceptance the mask is raised to the accepted level, supervisor mode is set and trace is cleared. The values from before the change are held for the core to push. A return-from-exception strobe, taken only while the block is idle, reloads the mask, supervisor and trace bits from values that the core supplies. The core lowers the mask this way, so interrupts nest only at strictly higher levels. User devices normally return vector numbers 64 to 255.

Top module: `irq_level_acceptor`

## Requirements
- R1: While reset is high and on the first cycle after it, the mask is 7, supervisor is 1, trace is 0, and acknowledge and stacking request are both 0.
- R2: When several request lines are high at the same boundary, the level reported on iack_level is the highest line index (irq_req bit n is level n).
- R3: A level from 1 to 6 is accepted only if it is strictly greater than the mask. A level equal to or below the mask raises no acknowledge.
- R4: Level 7 is accepted whatever the mask is, including mask 7. It is taken once for each rising edge of its line, and that edge must come at least one clock edge before the boundary. A line held high after service is not taken again.
- R5: Acceptance happens only on a clock edge where insn_end is 1 and the block is idle. Acknowledge is high from the next cycle.
- R6: In the cycle where acknowledge first shows, the mask equals the accepted level, supervisor is 1 and trace is 0. The saved outputs show the mask, supervisor and trace values from before acceptance.
- R7: On the first edge in the acknowledge phase where dev_vec_vld is 1, dev_vec is latched as the vector number. In the next cycle acknowledge is 0 and stacking request is 1.
- R8: While the stacking request is high, vec_addr (10 bits) equals the vector number times four.
- R9: If dev_vec_vld stays 0, acknowledge stays high for exactly 16 cycles. After that the vector number is 24 and spurious is 1.
- R10: The stacking request stays high until stack_done is 1. It is 0 from the cycle after that edge.
- R11: rte_req while idle loads the mask, supervisor and trace from rte_mask, rte_sup and rte_trace in the next cycle. It wins over an acceptance at the same edge, which is then not made. rte_req while not idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 7 | Request lines; bit n is level n (bits 7..1) |
| insn_end | input | 1 | Core is at an instruction boundary |
| rte_req | input | 1 | Return-from-exception strobe |
| rte_mask | input | 3 | Mask value to restore |
| rte_sup | input | 1 | Supervisor value to restore |
| rte_trace | input | 1 | Trace value to restore |
| dev_vec_vld | input | 1 | Device drives a valid vector number |
| dev_vec | input | 8 | Vector number from the device |
| stack_done | input | 1 | Core finished pushing PC and status |
| iack | output | 1 | Interrupt acknowledge phase |
| iack_level | output | 3 | Level being acknowledged |
| stack_req | output | 1 | Request to the core to stack and vector |
| vec_num | output | 8 | Latched vector number |
| vec_addr | output | 10 | Vector table byte address |
| spurious | output | 1 | Vector was substituted after a timeout |
| mask_lvl | output | 3 | Current interrupt mask |
| sup_mode | output | 1 | Supervisor bit |
| trace_mode | output | 1 | Trace bit |
| saved_mask | output | 3 | Mask before the last acceptance |
| saved_sup | output | 1 | Supervisor bit before the last acceptance |
| saved_trace | output | 1 | Trace bit before the last acceptance |

## Verification
Acknowledge, level and the new status bits appear one cycle after the boundary edge that accepts. The stacking request and the vector appear one cycle after the edge that carries the valid vector, or 16 acknowledge cycles later when no vector comes. A restore, and the drop of the stacking request, each show one cycle after their strobe. The bench drives every input just after a falling edge, so that the next rising edge consumes it, and it reads results at the following falling edge. The spurious case is checked at both the 16th acknowledge cycle and the cycle that follows it. A scoreboard queue holds the level, vector and spurious flag expected for each acceptance. It compares them at the cycle the stacking request rises.

// File: rtl/irqa_pkg.sv
package irqa_pkg;

    localparam int LVL_W      = 3;
    localparam int NUM_LVL    = (1 << LVL_W) - 1;
    localparam int NMI_LVL    = NUM_LVL;
    localparam int VEC_W      = 8;
    localparam int TAB_ADDR_W = VEC_W + 2;

    typedef logic [LVL_W-1:0]      lvl_t;
    typedef logic [VEC_W-1:0]      vec_t;
    typedef logic [TAB_ADDR_W-1:0] taddr_t;

    typedef struct packed {
        lvl_t mask;
        logic sup;
        logic trace;
    } sr_t;

    typedef struct packed {
        vec_t   num;
        taddr_t addr;
        logic   spur;
    } vec_rec_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACK   = 2'd1,
        ST_STACK = 2'd2
    } seq_st_e;

    localparam sr_t SR_RESET = '{mask: lvl_t'(NUM_LVL), sup: 1'b1, trace: 1'b0};

    // highest set index of the request vector, zero when none
    function automatic lvl_t top_level(input logic [NUM_LVL:1] lines);
        lvl_t r;
        r = '0;
        for (int i = 1; i <= NUM_LVL; i++) begin
            if (lines[i]) r = lvl_t'(i);
        end
        return r;
    endfunction

    // non-maskable level passes any mask, others need a strictly higher level
    function automatic logic level_wins(input lvl_t lvl, input lvl_t mask);
        return (lvl != '0) && ((lvl == lvl_t'(NMI_LVL)) || (lvl > mask));
    endfunction

    function automatic taddr_t table_addr(input vec_t v);
        return {v, 2'b00};
    endfunction

    function automatic vec_rec_t make_rec(input vec_t v, input logic spur);
        vec_rec_t r;
        r.num  = v;
        r.addr = table_addr(v);
        r.spur = spur;
        return r;
    endfunction

endpackage

// File: rtl/irqa_prio.sv
module irqa_prio
    import irqa_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NUM_LVL:1] irq_req,
    input  logic             nmi_clr,
    output lvl_t             cand
);

    logic             nmi_q;
    logic             nmi_pend_q;
    logic [NUM_LVL:1] eff;

    // the top level is edge-triggered: remember a rising edge until it is taken
    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_q      <= 1'b0;
            nmi_pend_q <= 1'b0;
        end else begin
            nmi_q      <= irq_req[NUM_LVL];
            nmi_pend_q <= (nmi_pend_q & ~nmi_clr) | (irq_req[NUM_LVL] & ~nmi_q);
        end
    end

    for (genvar g = 1; g <= NUM_LVL; g++) begin : g_eff
        if (g == NUM_LVL) begin : g_nmi
            assign eff[g] = nmi_pend_q;
        end else begin : g_lvl
            assign eff[g] = irq_req[g];
        end
    end

    assign cand = top_level(eff);

endmodule

// File: rtl/irqa_sr.sv
module irqa_sr
    import irqa_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ld_acc,
    input  lvl_t acc_lvl,
    input  logic ld_rte,
    input  sr_t  rte_val,
    output sr_t  cur,
    output sr_t  saved
);

    sr_t cur_q;
    sr_t saved_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q   <= SR_RESET;
            saved_q <= SR_RESET;
        end else if (ld_rte) begin
            cur_q <= rte_val;
        end else if (ld_acc) begin
            saved_q <= cur_q;
            cur_q   <= '{mask: acc_lvl, sup: 1'b1, trace: 1'b0};
        end
    end

    assign cur   = cur_q;
    assign saved = saved_q;

endmodule

// File: rtl/irqa_seq.sv
module irqa_seq
    import irqa_pkg::*;
#(
    parameter int TIMEOUT  = 16,
    parameter int SPUR_VEC = 24
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     insn_end,
    input  logic     rte_req,
    input  lvl_t     cand,
    input  lvl_t     mask,
    input  logic     dev_vec_vld,
    input  vec_t     dev_vec,
    input  logic     stack_done,
    output logic     accept,
    output logic     rte_take,
    output logic     iack,
    output lvl_t     iack_level,
    output logic     stack_req,
    output vec_rec_t rec
);

    localparam int                CNT_W = $clog2(TIMEOUT + 1);
    localparam logic [CNT_W-1:0]  LAST  = CNT_W'(TIMEOUT - 1);
    localparam vec_t              SPUR  = vec_t'(SPUR_VEC);

    seq_st_e          st;
    logic [CNT_W-1:0] cnt;
    lvl_t             lvl_q;
    vec_rec_t         rec_q;
    logic             idle;
    logic             timeout_hit;

    assign idle        = (st == ST_IDLE);
    assign rte_take    = idle & rte_req;
    assign accept      = idle & insn_end & ~rte_req & level_wins(cand, mask);
    assign timeout_hit = (st == ST_ACK) & ~dev_vec_vld & (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            cnt   <= '0;
            lvl_q <= '0;
            rec_q <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (accept) begin
                        st    <= ST_ACK;
                        cnt   <= '0;
                        lvl_q <= cand;
                    end
                end
                ST_ACK: begin
                    if (dev_vec_vld) begin
                        rec_q <= make_rec(dev_vec, 1'b0);
                        st    <= ST_STACK;
                    end else if (timeout_hit) begin
                        rec_q <= make_rec(SPUR, 1'b1);
                        st    <= ST_STACK;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_STACK: begin
                    if (stack_done) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign iack       = (st == ST_ACK);
    assign stack_req  = (st == ST_STACK);
    assign iack_level = lvl_q;
    assign rec        = rec_q;

endmodule

// File: rtl/irq_level_acceptor.sv
module irq_level_acceptor
    import irqa_pkg::*;
#(
    parameter int ACK_TIMEOUT = 16,
    parameter int SPUR_VEC    = 24
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_LVL:1]      irq_req,
    input  logic                  insn_end,
    input  logic                  rte_req,
    input  logic [LVL_W-1:0]      rte_mask,
    input  logic                  rte_sup,
    input  logic                  rte_trace,
    input  logic                  dev_vec_vld,
    input  logic [VEC_W-1:0]      dev_vec,
    input  logic                  stack_done,
    output logic                  iack,
    output logic [LVL_W-1:0]      iack_level,
    output logic                  stack_req,
    output logic [VEC_W-1:0]      vec_num,
    output logic [TAB_ADDR_W-1:0] vec_addr,
    output logic                  spurious,
    output logic [LVL_W-1:0]      mask_lvl,
    output logic                  sup_mode,
    output logic                  trace_mode,
    output logic [LVL_W-1:0]      saved_mask,
    output logic                  saved_sup,
    output logic                  saved_trace
);

    lvl_t     cand;
    logic     accept;
    logic     rte_take;
    sr_t      sr_cur;
    sr_t      sr_saved;
    sr_t      rte_val;
    vec_rec_t rec;
    lvl_t     lvl_ack;

    assign rte_val = '{mask: rte_mask, sup: rte_sup, trace: rte_trace};

    irqa_prio u_prio (
        .clk     (clk),
        .rst     (rst),
        .irq_req (irq_req),
        .nmi_clr (accept && (cand == lvl_t'(NMI_LVL))),
        .cand    (cand)
    );

    irqa_seq #(
        .TIMEOUT  (ACK_TIMEOUT),
        .SPUR_VEC (SPUR_VEC)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .insn_end    (insn_end),
        .rte_req     (rte_req),
        .cand        (cand),
        .mask        (sr_cur.mask),
        .dev_vec_vld (dev_vec_vld),
        .dev_vec     (dev_vec),
        .stack_done  (stack_done),
        .accept      (accept),
        .rte_take    (rte_take),
        .iack        (iack),
        .iack_level  (lvl_ack),
        .stack_req   (stack_req),
        .rec         (rec)
    );

    irqa_sr u_sr (
        .clk     (clk),
        .rst     (rst),
        .ld_acc  (accept),
        .acc_lvl (cand),
        .ld_rte  (rte_take),
        .rte_val (rte_val),
        .cur     (sr_cur),
        .saved   (sr_saved)
    );

    assign iack_level  = lvl_ack;
    assign vec_num     = rec.num;
    assign vec_addr    = rec.addr;
    assign spurious    = rec.spur;
    assign mask_lvl    = sr_cur.mask;
    assign sup_mode    = sr_cur.sup;
    assign trace_mode  = sr_cur.trace;
    assign saved_mask  = sr_saved.mask;
    assign saved_sup   = sr_saved.sup;
    assign saved_trace = sr_saved.trace;

endmodule

// File: rtl/irqa_chk.sv
module irqa_chk
    import irqa_pkg::*;
#(
    parameter int SPUR_VEC = 24
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  insn_end,
    input logic                  iack,
    input logic [LVL_W-1:0]      iack_level,
    input logic                  stack_req,
    input logic                  stack_done,
    input logic [VEC_W-1:0]      vec_num,
    input logic [TAB_ADDR_W-1:0] vec_addr,
    input logic                  spurious,
    input logic [LVL_W-1:0]      mask_lvl,
    input logic                  sup_mode,
    input logic                  trace_mode
);

    AST_ACK_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        $rose(iack) |-> $past(insn_end)); // R5

    AST_LEVEL_NONZERO: assert property (@(posedge clk) disable iff (rst)
        iack |-> (iack_level != '0)); // R2

    AST_LEVEL_ABOVE_MASK: assert property (@(posedge clk) disable iff (rst)
        $rose(iack) |-> ((iack_level == lvl_t'(NMI_LVL)) || (iack_level > $past(mask_lvl)))); // R3

    AST_MASK_RAISED: assert property (@(posedge clk) disable iff (rst)
        $rose(iack) |-> ((mask_lvl == iack_level) && sup_mode && !trace_mode)); // R6

    AST_PHASES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(iack && stack_req)); // R7

    AST_TABLE_ADDR: assert property (@(posedge clk) disable iff (rst)
        stack_req |-> ((vec_addr[1:0] == 2'b00) && (vec_addr[TAB_ADDR_W-1:2] == vec_num))); // R8

    AST_SPUR_VECTOR: assert property (@(posedge clk) disable iff (rst)
        (stack_req && spurious) |-> (vec_num == vec_t'(SPUR_VEC))); // R9

    AST_STACK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (stack_req && !stack_done) |=> stack_req); // R10

    AST_STACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (stack_req && stack_done) |=> (!stack_req && !iack)); // R10

endmodule

bind irq_level_acceptor irqa_chk #(.SPUR_VEC(SPUR_VEC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .insn_end   (insn_end),
    .iack       (iack),
    .iack_level (iack_level),
    .stack_req  (stack_req),
    .stack_done (stack_done),
    .vec_num    (vec_num),
    .vec_addr   (vec_addr),
    .spurious   (spurious),
    .mask_lvl   (mask_lvl),
    .sup_mode   (sup_mode),
    .trace_mode (trace_mode)
);

// File: tb/sim_irq_level_acceptor.sv
module sim_irq_level_acceptor;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:1] irq;
    logic       insn_end, rte_req, rte_sup, rte_trace;
    logic [2:0] rte_mask;
    logic       dev_vec_vld, stack_done;
    logic [7:0] dev_vec;
    logic       iack, stack_req, spurious, sup_mode, trace_mode, saved_sup, saved_trace;
    logic [2:0] iack_level, mask_lvl, saved_mask;
    logic [7:0] vec_num;
    logic [9:0] vec_addr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct packed {
        logic [2:0] lvl;
        logic [7:0] vec;
        logic       spur;
    } exp_t;

    exp_t exp_q[$];
    logic stk_prev = 1'b0;

    always #4 clk = ~clk;

    irq_level_acceptor u0 (
        .clk(clk), .rst(rst), .irq_req(irq), .insn_end(insn_end),
        .rte_req(rte_req), .rte_mask(rte_mask), .rte_sup(rte_sup), .rte_trace(rte_trace),
        .dev_vec_vld(dev_vec_vld), .dev_vec(dev_vec), .stack_done(stack_done),
        .iack(iack), .iack_level(iack_level), .stack_req(stack_req),
        .vec_num(vec_num), .vec_addr(vec_addr), .spurious(spurious),
        .mask_lvl(mask_lvl), .sup_mode(sup_mode), .trace_mode(trace_mode),
        .saved_mask(saved_mask), .saved_sup(saved_sup), .saved_trace(saved_trace)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver side: record what the next vector phase must produce
    task automatic expect_item(input logic [2:0] lvl, input logic [7:0] vec, input logic spur);
        exp_t e;
        e.lvl  = lvl;
        e.vec  = vec;
        e.spur = spur;
        exp_q.push_back(e);
    endtask

    task automatic give_vec(input logic [7:0] v);
        dev_vec     = v;
        dev_vec_vld = 1'b1;
        cyc(1);
        dev_vec_vld = 1'b0;
    endtask

    task automatic release_stack;
        stack_done = 1'b1;
        cyc(1);
        stack_done = 1'b0;
    endtask

    task automatic restore(input logic [2:0] m, input logic s, input logic t);
        rte_mask  = m;
        rte_sup   = s;
        rte_trace = t;
        rte_req   = 1'b1;
        cyc(1);
        rte_req   = 1'b0;
    endtask

    // monitor: compare at the cycle the stacking request rises
    always @(negedge clk) begin
        if (!rst && stack_req && !stk_prev) begin
            if (exp_q.size() == 0) begin
                chk("R7 unexpected vector phase", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk("R2 level", iack_level, e.lvl);
                chk("R7 vector", vec_num, e.vec);
                chk("R8 table address", vec_addr, {e.vec, 2'b00});
                chk("R9 spurious flag", spurious, e.spur);
            end
        end
        stk_prev = stack_req;
    end

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R10 watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; irq = '0; insn_end = 0; rte_req = 0; rte_mask = '0;
        rte_sup = 0; rte_trace = 0; dev_vec_vld = 0; dev_vec = '0; stack_done = 0;
        cyc(3);
        chk("R1 reset mask", mask_lvl, 3'd7);
        chk("R1 reset sup", sup_mode, 1'b1);
        chk("R1 reset trace", trace_mode, 1'b0);
        chk("R1 reset iack", iack, 1'b0);
        chk("R1 reset stack_req", stack_req, 1'b0);
        rst = 1'b0;
        cyc(1);
        chk("R1 after reset mask", mask_lvl, 3'd7);

        restore(3'd2, 1'b0, 1'b1);
        chk("R11 restored mask", mask_lvl, 3'd2);
        chk("R11 restored sup", sup_mode, 1'b0);
        chk("R11 restored trace", trace_mode, 1'b1);

        // levels 5 and 3 pending, no boundary yet
        irq[5] = 1'b1; irq[3] = 1'b1;
        cyc(3);
        chk("R5 no boundary no ack", iack, 1'b0);
        insn_end = 1'b1;
        expect_item(3'd5, 8'h45, 1'b0);
        cyc(1);
        insn_end = 1'b0;
        chk("R5 ack after boundary", iack, 1'b1);
        chk("R2 highest level", iack_level, 3'd5);
        chk("R6 mask raised", mask_lvl, 3'd5);
        chk("R6 sup set", sup_mode, 1'b1);
        chk("R6 trace cleared", trace_mode, 1'b0);
        chk("R6 saved mask", saved_mask, 3'd2);
        chk("R6 saved sup", saved_sup, 1'b0);
        chk("R6 saved trace", saved_trace, 1'b1);
        cyc(2);
        chk("R7 ack waits for vector", iack, 1'b1);
        give_vec(8'h45);
        chk("R7 ack dropped", iack, 1'b0);
        chk("R7 stack request", stack_req, 1'b1);
        restore(3'd0, 1'b0, 1'b0);
        chk("R11 restore ignored while busy", mask_lvl, 3'd5);
        chk("R10 stack held", stack_req, 1'b1);
        release_stack();
        chk("R10 stack released", stack_req, 1'b0);

        // level 5 against mask 5: equal, not taken
        insn_end = 1'b1;
        cyc(1);
        insn_end = 1'b0;
        chk("R3 equal level ignored", iack, 1'b0);
        chk("R3 mask unchanged", mask_lvl, 3'd5);

        // level 6 with no device answer
        irq[6] = 1'b1;
        insn_end = 1'b1;
        expect_item(3'd6, 8'd24, 1'b1);
        cyc(1);
        insn_end = 1'b0;
        chk("R3 higher level taken", iack_level, 3'd6);
        cyc(15);
        chk("R9 ack in 16th cycle", iack, 1'b1);
        cyc(1);
        chk("R9 ack ends after 16", iack, 1'b0);
        chk("R9 spurious stack", stack_req, 1'b1);
        chk("R9 spurious vector", vec_num, 8'd24);
        release_stack();
        irq = '0;
        restore(3'd7, 1'b1, 1'b0);

        // non-maskable level under mask 7
        irq[7] = 1'b1;
        cyc(1);
        insn_end = 1'b1;
        expect_item(3'd7, 8'hC8, 1'b0);
        cyc(1);
        insn_end = 1'b0;
        chk("R4 nmi taken at mask 7", iack, 1'b1);
        chk("R4 nmi level", iack_level, 3'd7);
        chk("R4 mask stays 7", mask_lvl, 3'd7);
        give_vec(8'hC8);
        chk("R8 address of 200", vec_addr, 10'h320);
        release_stack();
        insn_end = 1'b1;
        cyc(1);
        insn_end = 1'b0;
        chk("R4 held line not retaken", iack, 1'b0);
        irq[7] = 1'b0;
        cyc(1);
        irq[7] = 1'b1;
        cyc(1);
        insn_end = 1'b1;
        expect_item(3'd7, 8'hFF, 1'b0);
        cyc(1);
        insn_end = 1'b0;
        chk("R4 new edge taken", iack, 1'b1);
        give_vec(8'hFF);
        release_stack();
        irq = '0;

        // restore and boundary at the same edge with level 4 pending
        irq[4] = 1'b1;
        rte_mask = 3'd1; rte_sup = 1'b0; rte_trace = 1'b0;
        rte_req = 1'b1; insn_end = 1'b1;
        cyc(1);
        rte_req = 1'b0; insn_end = 1'b0;
        chk("R11 restore wins", iack, 1'b0);
        chk("R11 mask from restore", mask_lvl, 3'd1);
        insn_end = 1'b1;
        expect_item(3'd4, 8'h40, 1'b0);
        cyc(1);
        insn_end = 1'b0;
        chk("R5 taken at next boundary", iack_level, 3'd4);
        chk("R6 saved mask 1", saved_mask, 3'd1);
        give_vec(8'h40);
        release_stack();
        irq = '0;
        cyc(2);
        chk("R7 all vectors seen", exp_q.size(), 32'd0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule